// File: doc/BRIEF.md
# Coprocessor handshake controller

This block sits between a main processor's instruction pipeline and a numeric coprocessor that is reached through I/O space. The processor hands it a coprocessor opcode together with the memory operand's address and transfer direction. The controller holds the opcode back while the coprocessor reports it is still busy. It refuses the opcode if the coprocessor reports an unmasked error from the previous instruction. Otherwise it writes the opcode to a fixed I/O port. The bus cycles themselves are carried out by a separate bus controller, which the block drives through a request/done pair.

The coprocessor starts operand transfers itself by holding its operand-request line high. Each time it does, the controller issues a one-word transfer with the direction and address saved when the current instruction was dispatched, then advances the saved address by one word. A dispatch-time error produces a one-cycle fault pulse, and the controller stays blocked until the processor acknowledges the fault.

Top module: `copro_handshake`

## Requirements
- R1: After reset the controller is idle: `issue_ready` is 1 (while `cp_opreq` is 0), `bus_req` and `fault_pulse` are 0, and the saved operand context is cleared, so the first operand transfer uses address 0 with kind 2'b10.
- R2: An opcode is taken only in a cycle where `issue_ready` and `issue_valid` are both 1. While `cp_busy_n` is 0 the taken opcode waits: no bus request is raised and `issue_ready` stays 0.
- R3: Once `cp_busy_n` and `cp_error_n` are both 1 for a waiting opcode, a bus request with kind 2'b01 is raised, carrying address `CP_PORT` and the opcode zero-extended on `bus_wdata`.
- R4: `bus_req` stays 1, with `bus_kind`, `bus_addr` and `bus_wdata` unchanged, until the cycle in which `bus_done` is 1.
- R5: While `cp_opreq` is 1 in the idle or waiting state, an operand transfer is requested at the saved address, with kind 2'b10 (memory to coprocessor) when the saved direction is 0 and kind 2'b11 (coprocessor to memory) when it is 1.
- R6: Each completed operand transfer advances the saved address by `DW/8`. `bus_req` drops for at least one cycle afterwards, so a steady request yields exactly one transfer per `bus_done`.
- R7: The direction and address given with an opcode become the saved context only when that opcode's I/O write completes. Transfers requested before then use the previous context.
- R8: If `cp_error_n` is 0 when a waiting opcode would be sent, the opcode is dropped and never written. `fault_pulse` is 1 for exactly one cycle, and `issue_ready` stays 0 until `fault_ack` is 1.
- R9: In the waiting state an operand request is served before dispatch. The error input is examined before the busy input, so an error faults even while busy is asserted.
- R10: While blocked on a fault, `cp_opreq` is ignored and no bus request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Processor offers a coprocessor opcode |
| issue_opcode | input | OPW | Opcode to pass to the coprocessor |
| issue_dir | input | 1 | Operand direction: 0 memory to coprocessor, 1 coprocessor to memory |
| issue_addr | input | AW | Memory address of the instruction's operand |
| issue_ready | output | 1 | Controller can take an opcode this cycle |
| cp_busy_n | input | 1 | Coprocessor busy, active low, level-sensitive |
| cp_error_n | input | 1 | Coprocessor unmasked error, active low, level-sensitive |
| cp_opreq | input | 1 | Coprocessor operand request, active high, level-sensitive |
| fault_ack | input | 1 | Processor clears a pending fault |
| fault_pulse | output | 1 | One-cycle pulse when an opcode is refused due to an error |
| bus_req | output | 1 | Bus cycle request to the bus controller |
| bus_kind | output | 2 | 01 opcode I/O write, 10 memory to coprocessor, 11 coprocessor to memory |
| bus_addr | output | AW | I/O port or memory address of the requested cycle |
| bus_wdata | output | DW | Opcode for kind 01, zero otherwise |
| bus_done | input | 1 | Bus controller finished the requested cycle |

## Verification
The hardest situation to reach is an operand request that arrives while a new opcode is still waiting on the busy input. This must be served with the previous instruction's context rather than the one just handed in. The stimulus holds busy asserted after issuing an opcode with a fresh address, raises the operand request for exactly one transfer by dropping it on the falling edge after the bus model completes, and only then releases busy. This shows the old address was used and the new one took effect only after the opcode write. The fault path is reached similarly, by holding error and busy both low during a dispatch and then raising the operand request while blocked.

// File: rtl/copro_pkg.sv
package copro_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAIT  = 3'd1,
        ST_SEND  = 3'd2,
        ST_XFER  = 3'd3,
        ST_FAULT = 3'd4
    } cp_state_e;

    localparam logic [1:0] KIND_NONE   = 2'b00;
    localparam logic [1:0] KIND_OPCODE = 2'b01;
    localparam logic [1:0] KIND_MEM2CP = 2'b10;
    localparam logic [1:0] KIND_CP2MEM = 2'b11;

    typedef struct packed {
        cp_state_e st;
        logic      ret_wait;  // return to waiting state after a transfer
        logic      fault;     // registered fault pulse
    } seq_regs_t;

endpackage

// File: rtl/copro_ctx_reg.sv
module copro_ctx_reg #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int OPW = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_en,
    input  logic [OPW-1:0] cap_opcode,
    input  logic           cap_dir,
    input  logic [AW-1:0]  cap_addr,
    input  logic           commit_en,
    input  logic           step_en,
    output logic [OPW-1:0] pend_opcode,
    output logic           cur_dir,
    output logic [AW-1:0]  cur_addr
);

    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    typedef struct packed {
        logic [OPW-1:0] pop;
        logic           pdir;
        logic [AW-1:0]  paddr;
        logic           cdir;
        logic [AW-1:0]  caddr;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    always_comb begin
        ctx_d = ctx_q;
        if (cap_en) begin
            ctx_d.pop   = cap_opcode;
            ctx_d.pdir  = cap_dir;
            ctx_d.paddr = cap_addr;
        end
        if (commit_en) begin
            ctx_d.cdir  = ctx_q.pdir;
            ctx_d.caddr = ctx_q.paddr;
        end else if (step_en) begin
            ctx_d.caddr = ctx_q.caddr + STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign pend_opcode = ctx_q.pop;
    assign cur_dir     = ctx_q.cdir;
    assign cur_addr    = ctx_q.caddr;

endmodule

// File: rtl/copro_seq.sv
module copro_seq
    import copro_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue_valid,
    input  logic       cp_busy_n,
    input  logic       cp_error_n,
    input  logic       cp_opreq,
    input  logic       fault_ack,
    input  logic       bus_done,
    input  logic       cur_dir,
    output logic       issue_ready,
    output logic       cap_en,
    output logic       commit_en,
    output logic       step_en,
    output logic       sel_opcode,
    output logic       bus_req,
    output logic [1:0] bus_kind,
    output logic       fault_pulse
);

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d       = seq_q;
        seq_d.fault = 1'b0;
        issue_ready = 1'b0;
        cap_en      = 1'b0;
        commit_en   = 1'b0;
        step_en     = 1'b0;
        sel_opcode  = 1'b0;
        bus_req     = 1'b0;
        bus_kind    = KIND_NONE;
        unique case (seq_q.st)
            ST_IDLE: begin
                issue_ready = !cp_opreq;
                if (cp_opreq) begin
                    seq_d.st       = ST_XFER;
                    seq_d.ret_wait = 1'b0;
                end else if (issue_valid) begin
                    cap_en   = 1'b1;
                    seq_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (cp_opreq) begin
                    seq_d.st       = ST_XFER;
                    seq_d.ret_wait = 1'b1;
                end else if (!cp_error_n) begin
                    seq_d.st    = ST_FAULT;
                    seq_d.fault = 1'b1;
                end else if (cp_busy_n) begin
                    seq_d.st = ST_SEND;
                end
            end
            ST_SEND: begin
                bus_req    = 1'b1;
                bus_kind   = KIND_OPCODE;
                sel_opcode = 1'b1;
                if (bus_done) begin
                    commit_en = 1'b1;
                    seq_d.st  = ST_IDLE;
                end
            end
            ST_XFER: begin
                bus_req  = 1'b1;
                bus_kind = cur_dir ? KIND_CP2MEM : KIND_MEM2CP;
                if (bus_done) begin
                    step_en  = 1'b1;
                    seq_d.st = seq_q.ret_wait ? ST_WAIT : ST_IDLE;
                end
            end
            ST_FAULT: begin
                if (fault_ack) begin
                    seq_d.st = ST_IDLE;
                end
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, ret_wait: 1'b0, fault: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign fault_pulse = seq_q.fault;

endmodule

// File: rtl/copro_handshake.sv
module copro_handshake #(
    parameter int              AW      = 32,
    parameter int              DW      = 32,
    parameter int              OPW     = 11,
    parameter logic [AW-1:0]   CP_PORT = AW'(32'h0000_00F8)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           issue_valid,
    input  logic [OPW-1:0] issue_opcode,
    input  logic           issue_dir,
    input  logic [AW-1:0]  issue_addr,
    output logic           issue_ready,
    input  logic           cp_busy_n,
    input  logic           cp_error_n,
    input  logic           cp_opreq,
    input  logic           fault_ack,
    output logic           fault_pulse,
    output logic           bus_req,
    output logic [1:0]     bus_kind,
    output logic [AW-1:0]  bus_addr,
    output logic [DW-1:0]  bus_wdata,
    input  logic           bus_done
);

    logic           cap_en;
    logic           commit_en;
    logic           step_en;
    logic           sel_opcode;
    logic           cur_dir;
    logic [AW-1:0]  cur_addr;
    logic [OPW-1:0] pend_opcode;

    copro_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_valid (issue_valid),
        .cp_busy_n   (cp_busy_n),
        .cp_error_n  (cp_error_n),
        .cp_opreq    (cp_opreq),
        .fault_ack   (fault_ack),
        .bus_done    (bus_done),
        .cur_dir     (cur_dir),
        .issue_ready (issue_ready),
        .cap_en      (cap_en),
        .commit_en   (commit_en),
        .step_en     (step_en),
        .sel_opcode  (sel_opcode),
        .bus_req     (bus_req),
        .bus_kind    (bus_kind),
        .fault_pulse (fault_pulse)
    );

    copro_ctx_reg #(
        .AW  (AW),
        .DW  (DW),
        .OPW (OPW)
    ) u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_en      (cap_en),
        .cap_opcode  (issue_opcode),
        .cap_dir     (issue_dir),
        .cap_addr    (issue_addr),
        .commit_en   (commit_en),
        .step_en     (step_en),
        .pend_opcode (pend_opcode),
        .cur_dir     (cur_dir),
        .cur_addr    (cur_addr)
    );

    always_comb begin
        if (sel_opcode) begin
            bus_addr  = CP_PORT;
            bus_wdata = DW'(pend_opcode);
        end else begin
            bus_addr  = cur_addr;
            bus_wdata = '0;
        end
    end

endmodule

// File: rtl/copro_handshake_chk.sv
module copro_handshake_chk #(
    parameter int            AW      = 32,
    parameter int            DW      = 32,
    parameter logic [AW-1:0] CP_PORT = AW'(32'h0000_00F8)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue_ready,
    input logic          fault_pulse,
    input logic          bus_req,
    input logic [1:0]    bus_kind,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          bus_done
);

    // R4: request held steady until done
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_kind)
                                    && $stable(bus_addr) && $stable(bus_wdata)));

    // R3: opcode writes always go to the fixed port
    assert_opcode_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_kind == 2'b01) |-> (bus_addr == CP_PORT));

    // R6: request drops after a finished operand transfer
    assert_resample_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_done && bus_kind[1]) |=> !bus_req);

    // R8: fault pulse lasts one cycle and blocks new opcodes
    assert_fault_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |=> !fault_pulse);

    assert_fault_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> !issue_ready);

    // R10: no bus activity when a fault has just been raised
    assert_fault_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_pulse |-> !bus_req);

    // R2: no opcode is taken while a bus cycle is outstanding
    assert_no_take_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !issue_ready);

endmodule

bind copro_handshake copro_handshake_chk #(
    .AW      (AW),
    .DW      (DW),
    .CP_PORT (CP_PORT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_ready (issue_ready),
    .fault_pulse (fault_pulse),
    .bus_req     (bus_req),
    .bus_kind    (bus_kind),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_done    (bus_done)
);

// File: tb/sim_copro_handshake.sv
module sim_copro_handshake;

    localparam int            AW   = 32;
    localparam int            DW   = 32;
    localparam int            OPW  = 11;
    localparam logic [AW-1:0] PORT = 32'h0000_00F8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           issue_valid = 1'b0;
    logic [OPW-1:0] issue_opcode = '0;
    logic           issue_dir = 1'b0;
    logic [AW-1:0]  issue_addr = '0;
    logic           issue_ready;
    logic           cp_busy_n = 1'b1;
    logic           cp_error_n = 1'b1;
    logic           cp_opreq = 1'b0;
    logic           fault_ack = 1'b0;
    logic           fault_pulse;
    logic           bus_req;
    logic [1:0]     bus_kind;
    logic [AW-1:0]  bus_addr;
    logic [DW-1:0]  bus_wdata;
    logic           bus_done;

    copro_handshake #(.AW(AW), .DW(DW), .OPW(OPW), .CP_PORT(PORT)) u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .issue_opcode(issue_opcode), .issue_dir(issue_dir),
        .issue_addr(issue_addr), .issue_ready(issue_ready),
        .cp_busy_n(cp_busy_n), .cp_error_n(cp_error_n), .cp_opreq(cp_opreq),
        .fault_ack(fault_ack), .fault_pulse(fault_pulse), .bus_req(bus_req),
        .bus_kind(bus_kind), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_done(bus_done)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int n_fault = 0;
    bit finished = 1'b0;

    logic [1:0]  lg_kind [0:31];
    logic [31:0] lg_addr [0:31];
    logic [31:0] lg_data [0:31];
    int          log_n = 0;
    int          resp_delay = 0;

    task automatic chk_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) if (fault_pulse === 1'b1) n_fault++;

    // bus controller model
    initial begin
        bus_done = 1'b0;
        forever begin
            @(negedge clk);
            if (bus_req === 1'b1) begin
                int idx;
                idx = log_n % 32;
                lg_kind[idx] = bus_kind;
                lg_addr[idx] = bus_addr;
                lg_data[idx] = bus_wdata;
                log_n++;
                for (int i = 0; i < resp_delay; i++) begin
                    @(negedge clk);
                    chk_eq("R4", "request held", {31'b0, bus_req}, 32'd1);
                    chk_eq("R4", "address stable", bus_addr, lg_addr[idx]);
                end
                bus_done = 1'b1;
                @(negedge clk);
                bus_done = 1'b0;
            end
        end
    end

    task automatic do_issue(input logic [OPW-1:0] op, input logic dir,
                            input logic [AW-1:0] addr);
        @(negedge clk);
        while (issue_ready !== 1'b1) @(negedge clk);
        issue_valid  = 1'b1;
        issue_opcode = op;
        issue_dir    = dir;
        issue_addr   = addr;
        @(negedge clk);
        issue_valid  = 1'b0;
    endtask

    task automatic do_xfers(input int n);
        int base;
        base = log_n;
        cp_opreq = 1'b1;
        wait (log_n == base + n);
        @(negedge clk);
        cp_opreq = 1'b0;
        repeat (4) @(negedge clk);
        chk_eq("R6", "one transfer per done", log_n, base + n);
    endtask

    task automatic t_reset_state;
        @(negedge clk);
        chk_eq("R1", "ready after reset", {31'b0, issue_ready}, 32'd1);
        chk_eq("R1", "no request after reset", {31'b0, bus_req}, 32'd0);
        chk_eq("R1", "no fault after reset", {31'b0, fault_pulse}, 32'd0);
    endtask

    task automatic t_basic_dispatch;
        int base;
        base = log_n;
        cp_busy_n = 1'b0;
        do_issue(11'h1A5, 1'b0, 32'h0000_1000);
        repeat (5) @(negedge clk);
        chk_eq("R2", "no request while busy", {31'b0, bus_req}, 32'd0);
        chk_eq("R2", "no write while busy", log_n, base);
        chk_eq("R2", "not ready while waiting", {31'b0, issue_ready}, 32'd0);
        cp_busy_n = 1'b1;
        repeat (4) @(negedge clk);
        chk_eq("R3", "one opcode write", log_n, base + 1);
        chk_eq("R3", "opcode kind", {30'b0, lg_kind[base % 32]}, 32'd1);
        chk_eq("R3", "opcode port", lg_addr[base % 32], PORT);
        chk_eq("R3", "opcode data", lg_data[base % 32], 32'h0000_01A5);
        chk_eq("R3", "ready after send", {31'b0, issue_ready}, 32'd1);
    endtask

    task automatic t_load_transfers;
        int base;
        base = log_n;
        do_xfers(3);
        for (int i = 0; i < 3; i++) begin
            chk_eq("R5", "load kind", {30'b0, lg_kind[(base + i) % 32]}, 32'd2);
            chk_eq("R6", "address step", lg_addr[(base + i) % 32],
                   32'h0000_1000 + 32'(4 * i));
        end
    endtask

    task automatic t_context_swap;
        int base;
        cp_busy_n = 1'b0;
        do_issue(11'h0FF, 1'b1, 32'h0000_2000);
        repeat (2) @(negedge clk);
        base = log_n;
        do_xfers(1);
        chk_eq("R7", "old address while waiting", lg_addr[base % 32], 32'h0000_100C);
        chk_eq("R9", "old kind while waiting", {30'b0, lg_kind[base % 32]}, 32'd2);
        base = log_n;
        cp_busy_n = 1'b1;
        repeat (4) @(negedge clk);
        chk_eq("R9", "dispatch after transfer", {30'b0, lg_kind[base % 32]}, 32'd1);
        chk_eq("R3", "second opcode data", lg_data[base % 32], 32'h0000_00FF);
        base = log_n;
        do_xfers(2);
        chk_eq("R5", "store kind", {30'b0, lg_kind[base % 32]}, 32'd3);
        chk_eq("R7", "new address", lg_addr[base % 32], 32'h0000_2000);
        chk_eq("R6", "store step", lg_addr[(base + 1) % 32], 32'h0000_2004);
    endtask

    task automatic t_fault_path;
        int base;
        int f0;
        f0 = n_fault;
        base = log_n;
        cp_busy_n  = 1'b0;
        cp_error_n = 1'b0;
        do_issue(11'h055, 1'b1, 32'h0000_4000);
        repeat (4) @(negedge clk);
        chk_eq("R9", "error wins over busy", n_fault, f0 + 1);
        chk_eq("R8", "blocked on fault", {31'b0, issue_ready}, 32'd0);
        cp_opreq = 1'b1;
        repeat (5) @(negedge clk);
        chk_eq("R10", "request ignored while blocked", log_n, base);
        chk_eq("R10", "no bus request while blocked", {31'b0, bus_req}, 32'd0);
        cp_opreq = 1'b0;
        chk_eq("R8", "single fault pulse", n_fault, f0 + 1);
        fault_ack = 1'b1;
        @(negedge clk);
        fault_ack = 1'b0;
        chk_eq("R8", "ready after ack", {31'b0, issue_ready}, 32'd1);
        cp_error_n = 1'b1;
        cp_busy_n  = 1'b1;
        repeat (4) @(negedge clk);
        chk_eq("R8", "faulted opcode dropped", log_n, base);
        do_issue(11'h2AA, 1'b0, 32'h0000_3000);
        repeat (4) @(negedge clk);
        chk_eq("R3", "opcode after fault", lg_data[base % 32], 32'h0000_02AA);
        base = log_n;
        do_xfers(1);
        chk_eq("R7", "context from sent opcode", lg_addr[base % 32], 32'h0000_3000);
    endtask

    task automatic t_slow_bus;
        int base;
        base = log_n;
        resp_delay = 3;
        do_xfers(1);
        resp_delay = 0;
        chk_eq("R4", "slow transfer address", lg_addr[base % 32], 32'h0000_3004);
    endtask

    task automatic t_reset_clears;
        int base;
        cp_busy_n = 1'b0;
        do_issue(11'h111, 1'b1, 32'h0000_5000);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1", "ready after mid reset", {31'b0, issue_ready}, 32'd1);
        chk_eq("R1", "idle bus after mid reset", {31'b0, bus_req}, 32'd0);
        base = log_n;
        cp_busy_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R1", "pending opcode cleared", log_n, base);
        do_xfers(1);
        chk_eq("R1", "address cleared", lg_addr[base % 32], 32'h0000_0000);
        chk_eq("R1", "direction cleared", {30'b0, lg_kind[base % 32]}, 32'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_basic_dispatch();
        t_load_transfers();
        t_context_swap();
        t_fault_path();
        t_slow_bus();
        t_reset_clears();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule